// File: doc/BRIEF.md
# Reset Pulse Generator with Cause Flags

This block merges three reset requests into one active-low reset of fixed length: a push-button that pulls a shared bidirectional reset pin low, a timeout pulse from a watchdog, and a supply-low indication from an external comparator. A short press on the button is stretched into a full-length pulse, and the block drives the pin itself for that time, so a bouncing switch produces exactly one clean reset. While the supply is low, the reset is held. The full pulse is timed from the moment the supply recovers.

Each reset leaves a sticky cause flag that software reads and clears through a small register port. One flag means the watchdog fired. The other means the supply dipped or the button was pressed. A second register holds a 2-bit level code that is passed straight to the external supply comparator. A one-cycle strobe at the end of each pulse lets the watchdog restart its count.

Top module: `rstgen_top`

## Requirements
- R1: A `wdt_timeout` high seen at a clock edge while the reset is released (and `supply_low` is low) drives `rst_n_out` low for exactly PULSE_CYCLES clock cycles, starting after that edge.
- R2: `pin_in` passes through a two-flop synchronizer. A low on `pin_in`, even for one cycle, starts a PULSE_CYCLES-long reset at the third clock edge after the low appears. `pin_drive_low` is high for exactly the cycles in which `rst_n_out` is low.
- R3: A low on `pin_in` is ignored while the reset is active and for SYNC_STAGES+1 cycles after it ends. The block's own drive on the pin therefore never starts a second pulse.
- R4: While `supply_low` is high, `rst_n_out` stays low. After the first edge that sees `supply_low` low again, the reset remains low for PULSE_CYCLES more cycles. A supply dip during a running pulse re-enters this hold.
- R5: Status register (address 0): bit 7 is set by a watchdog-caused reset, and bit 6 is set by a supply-caused or pin-caused reset. Bits 5:0 read 0.
- R6: Writing 1 to status bit 7 or bit 6 clears that flag. Writing 0 leaves it unchanged. Hardware never clears a flag, and both flags can be set together.
- R7: If a flag-setting event and a write that clears the same flag fall on the same edge, the flag ends up set.
- R8: Level register (address 1): bits 1:0 hold the comparator level code, where 0, 1, 2 and 3 select ascending trip levels (2.6 V, 2.9 V, 3.9 V, 4.4 V). The code drives `trip_sel` and changes only on a write to address 1. Bits 7:2 read 0.
- R9: `pulse_done` is high for exactly one cycle: the first cycle in which `rst_n_out` is high again after a pulse.
- R10: After block reset `rst`, `rst_n_out` is high, `pin_drive_low` and `pulse_done` are low, and both registers read 0.
- R11: When several requests arrive on the same edge, supply-low wins over the watchdog, and the watchdog wins over the pin. Only the winner's flag is set. A watchdog timeout during an active reset is ignored and sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| pin_in | input | 1 | Sampled level of the bidirectional reset pin |
| pin_drive_low | output | 1 | Enable for the pad to pull the pin low |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| supply_low | input | 1 | Supply below trip level |
| rst_n_out | output | 1 | Active-low system reset |
| pulse_done | output | 1 | One-cycle strobe when the reset releases |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 level |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| trip_sel | output | 2 | Comparator level code |

## Verification
Two things can fall on the same edge: a hardware reset event setting a cause flag, and a software write clearing that same flag. The bench provokes this by raising `wdt_timeout` and issuing a status write of 0x80 in the same cycle. It then reads the status after the pulse and judges the result correct only if bit 7 is still set. A write of 0x80 with no event present confirms that the clear path works on its own.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_PULSE  = 2'd2,
        ST_SETTLE = 2'd3
    } rg_state_e;

    typedef enum logic [1:0] {
        TRIP_2V6 = 2'd0,
        TRIP_2V9 = 2'd1,
        TRIP_3V9 = 2'd2,
        TRIP_4V4 = 2'd3
    } trip_e;

    typedef struct packed {
        logic wdog;
        logic pwr_pin;
    } cause_t;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_LEVEL  = 1'b1;

    localparam int FLAG_WDOG_BIT = 7;
    localparam int FLAG_PWR_BIT  = 6;

    function automatic logic [7:0] pack_status(input logic wdog, input logic pwr_pin);
        logic [7:0] v;
        v = '0;
        v[FLAG_WDOG_BIT] = wdog;
        v[FLAG_PWR_BIT]  = pwr_pin;
        return v;
    endfunction

    function automatic logic [7:0] pack_level(input trip_e lvl);
        return {6'b0, lvl};
    endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b1;
                else     s_q <= d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rstgen_seq.sv
module rstgen_seq
    import rstgen_pkg::*;
#(
    parameter int PULSE_CYCLES  = 100000,
    parameter int SETTLE_CYCLES = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_low,
    input  logic   wdt_timeout,
    input  logic   supply_low,
    output logic   rst_active,
    output logic   pulse_done,
    output cause_t cause_set
);
    localparam int MAXC = (PULSE_CYCLES > SETTLE_CYCLES) ? PULSE_CYCLES : SETTLE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PULSE_LAST  = CW'(PULSE_CYCLES - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);

    rg_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done_q, done_d;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        done_d    = 1'b0;
        cause_set = '0;
        case (state_q)
            ST_IDLE, ST_SETTLE: begin
                if (supply_low) begin
                    state_d           = ST_HOLD;
                    cause_set.pwr_pin = 1'b1;
                end else if (wdt_timeout) begin
                    state_d        = ST_PULSE;
                    cnt_d          = '0;
                    cause_set.wdog = 1'b1;
                end else if (state_q == ST_IDLE && pin_low) begin
                    state_d           = ST_PULSE;
                    cnt_d             = '0;
                    cause_set.pwr_pin = 1'b1;
                end else if (state_q == ST_SETTLE) begin
                    if (cnt_q == SETTLE_LAST) state_d = ST_IDLE;
                    else                      cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!supply_low) begin
                    state_d = ST_PULSE;
                    cnt_d   = '0;
                end
            end
            ST_PULSE: begin
                if (supply_low) begin
                    state_d           = ST_HOLD;
                    cause_set.pwr_pin = 1'b1;
                end else if (cnt_q == PULSE_LAST) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    assign rst_active = (state_q == ST_HOLD) || (state_q == ST_PULSE);
    assign pulse_done = done_q;
endmodule

// File: rtl/rstgen_regs.sv
module rstgen_regs
    import rstgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cause_t     cause_set,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [1:0] trip_sel,
    output logic       wdog_flag,
    output logic       pwr_flag
);
    logic  wr_status, wr_level;
    logic  wdog_q, pwr_q;
    trip_e level_q;
    logic  unused_wdata_bits;

    assign wr_status = reg_wr && (reg_addr == ADDR_STATUS);
    assign wr_level  = reg_wr && (reg_addr == ADDR_LEVEL);
    assign unused_wdata_bits = ^reg_wdata[5:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            wdog_q  <= 1'b0;
            pwr_q   <= 1'b0;
            level_q <= TRIP_2V6;
        end else begin
            wdog_q <= cause_set.wdog ||
                      (wdog_q && !(wr_status && reg_wdata[FLAG_WDOG_BIT]));
            pwr_q  <= cause_set.pwr_pin ||
                      (pwr_q && !(wr_status && reg_wdata[FLAG_PWR_BIT]));
            if (wr_level) level_q <= trip_e'(reg_wdata[1:0]);
        end
    end

    always_comb begin
        if (reg_addr == ADDR_STATUS) reg_rdata = pack_status(wdog_q, pwr_q);
        else                         reg_rdata = pack_level(level_q);
    end

    assign trip_sel  = level_q;
    assign wdog_flag = wdog_q;
    assign pwr_flag  = pwr_q;
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int PULSE_CYCLES = 100000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    output logic       pin_drive_low,
    input  logic       wdt_timeout,
    input  logic       supply_low,
    output logic       rst_n_out,
    output logic       pulse_done,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [1:0] trip_sel
);
    localparam int SETTLE_CYCLES = SYNC_STAGES + 1;

    logic   pin_sync;
    logic   rst_active;
    cause_t cause_set;
    logic   wdog_flag, pwr_flag;

    rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    rstgen_seq #(
        .PULSE_CYCLES  (PULSE_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .pin_low     (!pin_sync),
        .wdt_timeout (wdt_timeout),
        .supply_low  (supply_low),
        .rst_active  (rst_active),
        .pulse_done  (pulse_done),
        .cause_set   (cause_set)
    );

    rstgen_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cause_set (cause_set),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trip_sel  (trip_sel),
        .wdog_flag (wdog_flag),
        .pwr_flag  (pwr_flag)
    );

    assign rst_n_out     = !rst_active;
    assign pin_drive_low = rst_active;
endmodule

// File: rtl/rstgen_checker.sv
module rstgen_checker #(
    parameter int PULSE_CYCLES = 100000
) (
    input logic       clk,
    input logic       rst,
    input logic       wdt_timeout,
    input logic       supply_low,
    input logic       rst_n_out,
    input logic       pulse_done,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [1:0] trip_sel,
    input logic       wdog_flag,
    input logic       pwr_flag
);
    logic [31:0] low_cnt;
    logic        clr_wdog, clr_pwr;

    always_ff @(posedge clk) begin
        if (rst)                        low_cnt <= '0;
        else if (rst_n_out)             low_cnt <= '0;
        else if (low_cnt != 32'hFFFF_FFFF) low_cnt <= low_cnt + 1'b1;
    end

    assign clr_wdog = reg_wr && (reg_addr == 1'b0) && reg_wdata[7];
    assign clr_pwr  = reg_wr && (reg_addr == 1'b0) && reg_wdata[6];

    assert_min_length_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_out) |-> (low_cnt >= 32'(PULSE_CYCLES)));

    assert_supply_holds_R4: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> !rst_n_out);

    assert_wdog_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (wdt_timeout && rst_n_out && !supply_low) |=> wdog_flag);

    assert_wdog_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (wdog_flag && !clr_wdog) |=> wdog_flag);

    assert_pwr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (pwr_flag && !clr_pwr) |=> pwr_flag);

    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wdt_timeout && rst_n_out && !supply_low && clr_wdog) |=> wdog_flag);

    assert_level_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == 1'b1) |=> $stable(trip_sel));

    assert_done_on_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_out) |-> pulse_done);

    assert_done_only_on_release_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_done |-> $rose(rst_n_out));
endmodule

bind rstgen_top rstgen_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wdt_timeout (wdt_timeout),
    .supply_low  (supply_low),
    .rst_n_out   (rst_n_out),
    .pulse_done  (pulse_done),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .trip_sel    (trip_sel),
    .wdog_flag   (wdog_flag),
    .pwr_flag    (pwr_flag)
);

// File: tb/rstgen_top_tb_top.sv
module rstgen_top_tb_top;
    localparam int P = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_low = 1'b0;
    logic       pin_in;
    logic       pin_drive_low;
    logic       wdt_timeout = 1'b0;
    logic       supply_low = 1'b0;
    logic       rst_n_out;
    logic       pulse_done;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] trip_sel;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    assign pin_in = !(ext_low || pin_drive_low);

    rstgen_top #(.PULSE_CYCLES(P), .SYNC_STAGES(2)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .pin_in        (pin_in),
        .pin_drive_low (pin_drive_low),
        .wdt_timeout   (wdt_timeout),
        .supply_low    (supply_low),
        .rst_n_out     (rst_n_out),
        .pulse_done    (pulse_done),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .trip_sel      (trip_sel)
    );

    // kind: 0 watchdog, 1 pin low, 2 supply low; hold in cycles
    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  hold;
        logic [15:0] exp_len;
        logic [7:0]  exp_flags;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'd0, 16'(P),     8'h80},
        '{2'd1, 8'd1, 16'(P),     8'h40},
        '{2'd1, 8'd3, 16'(P),     8'h40},
        '{2'd2, 8'd5, 16'(P + 1), 8'h40},
        '{2'd2, 8'd1, 16'(P + 1), 8'h40},
        '{2'd0, 8'd0, 16'(P),     8'h80}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic measure(output int n, output logic dn);
        int w;
        w = 0; n = 0;
        while (rst_n_out && w < 10) begin @(negedge clk); w++; end
        while (!rst_n_out && n < 1000) begin n++; @(negedge clk); end
        dn = pulse_done;
    endtask

    task automatic apply(input logic [1:0] kind, input int hold);
        @(negedge clk);
        case (kind)
            2'd0: begin wdt_timeout = 1'b1; @(negedge clk); wdt_timeout = 1'b0; end
            2'd1: begin ext_low = 1'b1; repeat (hold) @(negedge clk); ext_low = 1'b0; end
            default: begin supply_low = 1'b1; repeat (hold) @(negedge clk); supply_low = 1'b0; end
        endcase
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int         len;
        logic       dn;
        int         extra;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 rst_n_out", 32'(rst_n_out), 32'd1);
        chk("R10 pin_drive_low", 32'(pin_drive_low), 32'd0);
        chk("R10 pulse_done", 32'(pulse_done), 32'd0);
        reg_read(1'b0, rd); chk("R10 status", 32'(rd), 32'h00);
        reg_read(1'b1, rd); chk("R10 level", 32'(rd), 32'h00);

        // vector table: R1 watchdog, R2 pin, R4 supply, R5 flags, R9 strobe
        for (int i = 0; i < 6; i++) begin
            reg_write(1'b0, 8'hC0);
            apply(VECS[i].kind, int'(VECS[i].hold));
            measure(len, dn);
            chk($sformatf("R1/R2/R4 length vec%0d", i), 32'(len), 32'(VECS[i].exp_len));
            chk($sformatf("R9 pulse_done vec%0d", i), 32'(dn), 32'd1);
            @(negedge clk);
            chk($sformatf("R9 strobe one cycle vec%0d", i), 32'(pulse_done), 32'd0);
            repeat (4) @(negedge clk);
            reg_read(1'b0, rd);
            chk($sformatf("R5 flags vec%0d", i), 32'(rd), 32'(VECS[i].exp_flags));
        end

        // R8 level register
        reg_write(1'b1, 8'hFF);
        reg_read(1'b1, rd); chk("R8 level readback", 32'(rd), 32'h03);
        chk("R8 trip_sel", 32'(trip_sel), 32'd3);
        reg_write(1'b1, 8'h02);
        reg_write(1'b0, 8'hFF);
        chk("R8 trip_sel unaffected by status write", 32'(trip_sel), 32'd2);
        reg_read(1'b1, rd); chk("R8 level code 2", 32'(rd), 32'h02);

        // R6 both flags, selective clear
        reg_write(1'b0, 8'hC0);
        apply(2'd0, 0); measure(len, dn); repeat (4) @(negedge clk);
        apply(2'd1, 1); measure(len, dn); repeat (4) @(negedge clk);
        reg_read(1'b0, rd); chk("R6 both flags set", 32'(rd), 32'hC0);
        reg_write(1'b0, 8'h40);
        reg_read(1'b0, rd); chk("R6 clear bit6 only", 32'(rd), 32'h80);
        reg_write(1'b0, 8'h00);
        reg_read(1'b0, rd); chk("R6 zero write no effect", 32'(rd), 32'h80);
        reg_write(1'b0, 8'h80);
        reg_read(1'b0, rd); chk("R6 clear bit7", 32'(rd), 32'h00);

        // R7 set beats clear in the same cycle
        @(negedge clk);
        wdt_timeout = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h80;
        @(negedge clk);
        wdt_timeout = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        measure(len, dn);
        chk("R7 pulse length", 32'(len), 32'(P));
        repeat (4) @(negedge clk);
        reg_read(1'b0, rd); chk("R7 flag survives clear", 32'(rd), 32'h80);

        // R3 and R11: ignored pin and watchdog during a pulse
        reg_write(1'b0, 8'hC0);
        apply(2'd1, 1);
        while (rst_n_out) @(negedge clk);
        chk("R2 drive low mirrors reset", 32'(pin_drive_low), 32'd1);
        reg_write(1'b0, 8'hC0);
        @(negedge clk);
        wdt_timeout = 1'b1; ext_low = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0; ext_low = 1'b0;
        while (!rst_n_out) @(negedge clk);
        extra = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!rst_n_out) extra++;
        end
        chk("R3 no retrigger after pulse", 32'(extra), 32'd0);
        reg_read(1'b0, rd); chk("R11 watchdog in pulse sets no flag", 32'(rd), 32'h00);

        // R11 priority: supply and watchdog on the same edge
        reg_write(1'b0, 8'hC0);
        @(negedge clk);
        wdt_timeout = 1'b1; supply_low = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0; supply_low = 1'b0;
        measure(len, dn);
        chk("R11 supply wins length", 32'(len), 32'(P + 1));
        repeat (4) @(negedge clk);
        reg_read(1'b0, rd); chk("R11 only supply flag", 32'(rd), 32'h40);

        // R11 priority: watchdog and pin on the same edge path
        reg_write(1'b0, 8'hC0);
        @(negedge clk);
        wdt_timeout = 1'b1; ext_low = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0; ext_low = 1'b0;
        measure(len, dn);
        chk("R11 watchdog over pin length", 32'(len), 32'(P));
        repeat (4) @(negedge clk);
        reg_read(1'b0, rd); chk("R11 only watchdog flag", 32'(rd), 32'h80);

        // R4 supply dip during a running pulse
        reg_write(1'b0, 8'hC0);
        apply(2'd0, 0);
        repeat (5) @(negedge clk);
        supply_low = 1'b1;
        repeat (3) @(negedge clk);
        supply_low = 1'b0;
        measure(len, dn);
        chk("R4 re-hold then full pulse", 32'(len), 32'(P + 1));
        repeat (4) @(negedge clk);
        reg_read(1'b0, rd); chk("R4 both causes recorded", 32'(rd), 32'hC0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule